// File: doc/BRIEF.md
# Memory-Mapped Extended Configuration Decoder

This block sits on the processor's memory request path and watches for accesses that land inside a programmable configuration window. An access inside the window becomes a configuration request. The request names a bus, a device, a function and a 12-bit register offset, so each function reaches a 4 KB register space. The low 256 bytes of that space are the legacy-compatible part and offsets 256 to 4095 are the extended part. Every other access goes to the normal memory path with all its fields unchanged. This includes any access made while the window is off.

A single base register controls the window. It holds an enable bit, a two-bit size code and the high address bits of the window base. The size code picks a 256 MB, 128 MB or 64 MB window. A smaller window compares more high address bits against the base and keeps fewer bits for the bus number. The block accepts one read at a time. It holds off new requests until the read data comes back from the path the read was sent to. A configuration read flagged as unclaimed returns all-ones data.

Top module: `ecam_window_decoder`

## Requirements
- R1: After reset the base register reads 0, no request or response is valid, and `m_ready` is 1.
- R2: A write to the base register keeps bit 0 (enable), bits 2:1 (size code) and bits 35:26 (window base). All other bits read back as 0. The new value is visible on `base_rdata` one cycle after the write.
- R3: With enable at 0, or with size code 11, every accepted access goes to the pass-through path.
- R4: Size code 00 (256 MB) hits when address bits 35:28 equal base bits 35:28. The bus number is address bits 27:20.
- R5: Size code 01 (128 MB) hits when address bits 35:27 equal base bits 35:27. The bus number is address bits 26:20, zero-extended to 8 bits.
- R6: Size code 10 (64 MB) hits when address bits 35:26 equal base bits 35:26. The bus number is address bits 25:20, zero-extended to 8 bits.
- R7: On a hit, the device is taken from address bits 19:15, the function from bits 14:12 and the offset from bits 11:0, including offsets of 256 and above. The write flag, write data and byte enables are carried along.
- R8: An accepted access appears on exactly one path one cycle after acceptance. The pass-through path repeats the address, write flag, data and byte enables exactly.
- R9: After a read is accepted, `m_ready` stays 0 until the read data is returned. The data is returned one cycle after a response arrives on the path the read used. A response on the other path is ignored. Writes never lower `m_ready`.
- R10: A configuration read whose response carries `c_err` returns all-ones data.
- R11: If a base register write and an access are accepted in the same cycle, the access is decoded with the base value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 36 | Base register write value |
| base_rdata | output | 36 | Current base register value |
| m_valid | input | 1 | Memory-side access valid |
| m_ready | output | 1 | Memory-side access accepted when high |
| m_write | input | 1 | Access is a write |
| m_addr | input | 36 | Access address |
| m_wdata | input | 32 | Write data |
| m_be | input | 4 | Byte enables |
| m_rvalid | output | 1 | Read data valid |
| m_rdata | output | 32 | Read data |
| c_valid | output | 1 | Configuration request valid |
| c_write | output | 1 | Configuration request is a write |
| c_bus | output | 8 | Target bus |
| c_dev | output | 5 | Target device |
| c_fn | output | 3 | Target function |
| c_off | output | 12 | Register offset |
| c_wdata | output | 32 | Configuration write data |
| c_be | output | 4 | Configuration byte enables |
| c_rvalid | input | 1 | Configuration read response valid |
| c_rdata | input | 32 | Configuration read data |
| c_err | input | 1 | No function claimed the read |
| p_valid | output | 1 | Pass-through request valid |
| p_write | output | 1 | Pass-through is a write |
| p_addr | output | 36 | Pass-through address |
| p_wdata | output | 32 | Pass-through write data |
| p_be | output | 4 | Pass-through byte enables |
| p_rvalid | input | 1 | Pass-through read response valid |
| p_rdata | input | 32 | Pass-through read data |

## Verification
Two events can share a cycle: a change to the base register and an access that the new value would route differently. The bench drives both in one cycle, in both directions: the window is switched on while an access is accepted, and switched off while an access is accepted. It then checks that the access follows the old routing and that the next access follows the new one. A second overlap is a stray response on the unused path while a read is waiting. The bench checks that this response produces no read data and leaves `m_ready` low.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  localparam int ADDR_W    = 36;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int OFF_W     = 12;
  localparam int NUM_SIZES = 3;
  localparam int BUS_LSB   = OFF_W + FN_W + DEV_W;
  localparam int WIN_TOP   = BUS_LSB + BUS_W;
  localparam int BASE_LSB  = WIN_TOP - NUM_SIZES + 1;
  localparam int BASE_HI_W = ADDR_W - BASE_LSB;

  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [OFF_W-1:0] off;
  } cfg_tgt_t;
endpackage

// File: rtl/ecam_base_reg.sv
module ecam_base_reg
  import ecam_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] q
);
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    ({ADDR_W{1'b1}} << BASE_LSB) | ADDR_W'(7);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & KEEP_MASK;
  end
endmodule

// File: rtl/ecam_addr_decode.sv
module ecam_addr_decode
  import ecam_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 en,
  input  logic [1:0]           size,
  input  logic [BASE_HI_W-1:0] base_hi,
  output logic                 hit,
  output cfg_tgt_t             tgt
);
  logic [NUM_SIZES-1:0] hit_v;
  logic [BUS_W-1:0]     bus_v [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int LO = WIN_TOP - k;
    assign hit_v[k] = (addr[ADDR_W-1:LO] == base_hi[BASE_HI_W-1:LO-BASE_LSB]);
    assign bus_v[k] = BUS_W'(addr[LO-1:BUS_LSB]);
  end

  always_comb begin
    hit     = 1'b0;
    tgt.bus = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (int'(size) == k) begin
        hit     = en && hit_v[k];
        tgt.bus = bus_v[k];
      end
    end
    tgt.dev = addr[BUS_LSB-1:OFF_W+FN_W];
    tgt.fn  = addr[OFF_W+FN_W-1:OFF_W];
    tgt.off = addr[OFF_W-1:0];
  end
endmodule

// File: rtl/ecam_resp_merge.sv
module ecam_resp_merge #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_accept,
  input  logic              rd_to_cfg,
  input  logic              c_rvalid,
  input  logic [DATA_W-1:0] c_rdata,
  input  logic              c_err,
  input  logic              p_rvalid,
  input  logic [DATA_W-1:0] p_rdata,
  output logic              busy,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata
);
  logic route_cfg;
  logic take;

  assign take = route_cfg ? c_rvalid : p_rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      route_cfg <= 1'b0;
      m_rvalid  <= 1'b0;
      m_rdata   <= '0;
    end else begin
      m_rvalid <= 1'b0;
      if (busy && take) begin
        m_rvalid <= 1'b1;
        m_rdata  <= route_cfg ? (c_err ? {DATA_W{1'b1}} : c_rdata) : p_rdata;
        busy     <= 1'b0;
      end else if (rd_accept) begin
        busy      <= 1'b1;
        route_cfg <= rd_to_cfg;
      end
    end
  end

  assert_rdata_after_wait_R9: assert property (@(posedge clk) disable iff (rst)
    m_rvalid |-> $past(busy));
  assert_unclaimed_ones_R10: assert property (@(posedge clk) disable iff (rst)
    (m_rvalid && $past(route_cfg && c_rvalid && c_err)) |-> (m_rdata == {DATA_W{1'b1}}));
endmodule

// File: rtl/ecam_window_decoder.sv
module ecam_window_decoder
  import ecam_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] base_rdata,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic              m_write,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [BE_W-1:0]   m_be,
  output logic              m_rvalid,
  output logic [DATA_W-1:0] m_rdata,
  output logic              c_valid,
  output logic              c_write,
  output logic [BUS_W-1:0]  c_bus,
  output logic [DEV_W-1:0]  c_dev,
  output logic [FN_W-1:0]   c_fn,
  output logic [OFF_W-1:0]  c_off,
  output logic [DATA_W-1:0] c_wdata,
  output logic [BE_W-1:0]   c_be,
  input  logic              c_rvalid,
  input  logic [DATA_W-1:0] c_rdata,
  input  logic              c_err,
  output logic              p_valid,
  output logic              p_write,
  output logic [ADDR_W-1:0] p_addr,
  output logic [DATA_W-1:0] p_wdata,
  output logic [BE_W-1:0]   p_be,
  input  logic              p_rvalid,
  input  logic [DATA_W-1:0] p_rdata
);
  logic [ADDR_W-1:0] base_q;
  logic              hit;
  cfg_tgt_t          tgt, tgt_q;
  logic              busy;
  logic              acc;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;

  assign m_ready    = !busy;
  assign acc        = m_valid && m_ready;
  assign base_rdata = base_q;

  ecam_base_reg u_base (
    .clk   (clk),
    .rst   (rst),
    .we    (base_we),
    .wdata (base_wdata),
    .q     (base_q)
  );

  ecam_addr_decode u_dec (
    .addr    (m_addr),
    .en      (base_q[0]),
    .size    (base_q[2:1]),
    .base_hi (base_q[ADDR_W-1:BASE_LSB]),
    .hit     (hit),
    .tgt     (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid <= 1'b0;
      p_valid <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      tgt_q   <= '0;
    end else begin
      c_valid <= acc && hit;
      p_valid <= acc && !hit;
      if (acc) begin
        wr_q    <= m_write;
        addr_q  <= m_addr;
        wdata_q <= m_wdata;
        be_q    <= m_be;
        tgt_q   <= tgt;
      end
    end
  end

  assign c_write = wr_q;
  assign c_bus   = tgt_q.bus;
  assign c_dev   = tgt_q.dev;
  assign c_fn    = tgt_q.fn;
  assign c_off   = tgt_q.off;
  assign c_wdata = wdata_q;
  assign c_be    = be_q;
  assign p_write = wr_q;
  assign p_addr  = addr_q;
  assign p_wdata = wdata_q;
  assign p_be    = be_q;

  ecam_resp_merge #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .rd_accept (acc && !m_write),
    .rd_to_cfg (hit),
    .c_rvalid  (c_rvalid),
    .c_rdata   (c_rdata),
    .c_err     (c_err),
    .p_rvalid  (p_rvalid),
    .p_rdata   (p_rdata),
    .busy      (busy),
    .m_rvalid  (m_rvalid),
    .m_rdata   (m_rdata)
  );

  assert_single_path_R8: assert property (@(posedge clk) disable iff (rst)
    !(c_valid && p_valid));
  assert_pass_addr_R8: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> (p_addr == $past(m_addr)));
  assert_cfg_needs_window_R3: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> ($past(base_q[0]) && ($past(base_q[2:1]) != 2'b11)));
  assert_read_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    $past(m_valid && m_ready && !m_write) |-> !m_ready);
endmodule

// File: tb/ecam_window_decoder_bench.sv
module ecam_window_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [35:0] base_wdata = '0;
  logic [35:0] base_rdata;
  logic        m_valid = 1'b0, m_write = 1'b0;
  logic        m_ready;
  logic [35:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [3:0]  m_be = '0;
  logic        m_rvalid;
  logic [31:0] m_rdata;
  logic        c_valid, c_write;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_fn;
  logic [11:0] c_off;
  logic [31:0] c_wdata;
  logic [3:0]  c_be;
  logic        c_rvalid = 1'b0, c_err = 1'b0;
  logic [31:0] c_rdata = '0;
  logic        p_valid, p_write;
  logic [35:0] p_addr;
  logic [31:0] p_wdata;
  logic [3:0]  p_be;
  logic        p_rvalid = 1'b0;
  logic [31:0] p_rdata = '0;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecam_window_decoder u_ecam_window_decoder (.*);

  // reference model state
  logic [35:0] mbase;
  bit          mbusy, mroute;
  bit          e_cv, e_pv, e_wr, e_rv;
  logic [35:0] e_addr;
  logic [31:0] e_wd, e_rd;
  logic [3:0]  e_be;
  logic [7:0]  e_bus;

  function automatic bit model_hit(input logic [35:0] a, input logic [35:0] b, output logic [7:0] bus);
    bus = 8'h00;
    if (!b[0]) return 0;
    case (b[2:1])
      2'b00: begin bus = a[27:20];         return a[35:28] == b[35:28]; end
      2'b01: begin bus = {1'b0, a[26:20]}; return a[35:27] == b[35:27]; end
      2'b10: begin bus = {2'b0, a[25:20]}; return a[35:26] == b[35:26]; end
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mbase = '0; mbusy = 0; mroute = 0;
      e_cv = 0; e_pv = 0; e_rv = 0;
    end else begin
      bit acc, h;
      logic [7:0] bb;
      acc = m_valid && !mbusy;
      h   = model_hit(m_addr, mbase, bb);
      e_cv = acc && h;
      e_pv = acc && !h;
      if (acc) begin
        e_wr = m_write; e_addr = m_addr; e_wd = m_wdata; e_be = m_be; e_bus = bb;
      end
      e_rv = mbusy && (mroute ? c_rvalid : p_rvalid);
      if (e_rv) begin
        e_rd  = mroute ? (c_err ? 32'hFFFF_FFFF : c_rdata) : p_rdata;
        mbusy = 0;
      end
      if (acc && !m_write) begin mbusy = 1; mroute = h; end
      if (base_we) mbase = base_wdata & {10'h3FF, 23'h0, 3'h7};
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 base readback", base_rdata, mbase);
      chk("R9 m_ready", m_ready, !mbusy);
      chk("R8 c_valid", c_valid, e_cv);
      chk("R8 p_valid", p_valid, e_pv);
      chk("R9 m_rvalid", m_rvalid, e_rv);
      if (e_rv) chk("R10 m_rdata", m_rdata, e_rd);
      if (e_cv) begin
        chk("R7 c_bus", c_bus, e_bus);
        chk("R7 c_dev", c_dev, e_addr[19:15]);
        chk("R7 c_fn", c_fn, e_addr[14:12]);
        chk("R7 c_off", c_off, e_addr[11:0]);
        chk("R7 c_write", c_write, e_wr);
        chk("R7 c_wdata", c_wdata, e_wd);
        chk("R7 c_be", c_be, e_be);
      end
      if (e_pv) begin
        chk("R8 p_addr", p_addr, e_addr);
        chk("R8 p_write", p_write, e_wr);
        chk("R8 p_wdata", p_wdata, e_wd);
        chk("R8 p_be", p_be, e_be);
      end
    end
  end

  task automatic issue(input bit wr, input logic [35:0] a, input bit exp_cfg, input string tag,
                       input bit bwe = 0, input logic [35:0] bwd = '0);
    while (!m_ready) @(negedge clk);
    m_valid = 1; m_write = wr; m_addr = a;
    m_wdata = a[31:0] ^ 32'h5A5A_0000; m_be = a[3:0] | 4'h1;
    base_we = bwe; base_wdata = bwd;
    @(negedge clk);
    m_valid = 0; base_we = 0;
    chk(tag, {c_valid, p_valid}, exp_cfg ? 2'b10 : 2'b01);
  endtask

  task automatic respond(input bit to_cfg, input logic [31:0] d, input bit err, input string tag);
    if (to_cfg) begin c_rvalid = 1; c_rdata = d; c_err = err; end
    else        begin p_rvalid = 1; p_rdata = d; end
    @(negedge clk);
    c_rvalid = 0; p_rvalid = 0; c_err = 0;
    chk(tag, {m_rvalid, m_rdata}, {1'b1, err ? 32'hFFFF_FFFF : d});
  endtask

  task automatic set_base(input logic [35:0] v);
    base_we = 1; base_wdata = v;
    @(negedge clk);
    base_we = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 base", base_rdata, 36'h0);
    chk("R1 ready", m_ready, 1'b1);
    chk("R1 valids", {c_valid, p_valid, m_rvalid}, 3'b000);

    // window off: everything passes
    issue(0, 36'h0_F800_1000, 0, "R3 disabled pass");
    respond(0, 32'h1111_2222, 0, "R9 pass read data");

    // 256 MB window, junk in unused bits
    set_base(36'h0_F8FF_FFF9);
    chk("R2 masked write", base_rdata, 36'h0_F800_0001);
    issue(0, 36'h0_F8A7_B456, 1, "R4 hit 256MB");
    chk("R4 bus", c_bus, 8'h8A);
    chk("R7 ext offset", c_off, 12'h456);
    p_rvalid = 1; p_rdata = 32'hDEAD_0000;
    @(negedge clk);
    p_rvalid = 0;
    chk("R9 other path ignored", {m_rvalid, m_ready}, 2'b00);
    respond(1, 32'hCAFE_F00D, 0, "R9 cfg read data");
    issue(0, 36'h0_E000_0000, 0, "R4 miss");
    respond(0, 32'h3333_4444, 0, "R8 pass read");
    issue(0, 36'h0_F80F_8000, 1, "R10 unclaimed read");
    respond(1, 32'h0000_0000, 1, "R10 all ones");
    issue(1, 36'h0_F800_8010, 1, "R7 cfg write");
    chk("R9 write keeps ready", m_ready, 1'b1);

    // 128 MB window
    set_base(36'h0_F000_0003);
    issue(1, 36'h0_F7F0_0000, 1, "R5 hit 128MB");
    chk("R5 bus", c_bus, 8'h7F);
    issue(1, 36'h0_F800_0000, 0, "R5 miss high half");

    // 64 MB window
    set_base(36'h0_EC00_0005);
    issue(0, 36'h0_EFF0_1000, 1, "R6 hit 64MB");
    chk("R6 bus", c_bus, 8'h3F);
    respond(1, 32'h5555_6666, 0, "R6 read data");
    issue(1, 36'h0_F000_0000, 0, "R6 miss");

    // reserved size code
    set_base(36'h0_EC00_0007);
    issue(1, 36'h0_EC00_0000, 0, "R3 reserved size");

    // same-cycle base write and access
    issue(1, 36'h0_EC00_0000, 0, "R11 enable with access uses old", 1, 36'h0_EC00_0005);
    issue(1, 36'h0_EC00_0000, 1, "R11 next access uses new");
    issue(1, 36'h0_EC00_0000, 1, "R11 disable with access uses old", 1, 36'h0);
    issue(1, 36'h0_EC00_0000, 0, "R11 after disable passes");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule